// File: doc/BRIEF.md
# Sequential Byte-Sliced Wide Multiplier

This block forms the product of two 32-bit operands with one 8x8 unsigned multiplier that is reused over several clock cycles. Each operand is split into four base-256 digits. The block works through the digit pairs in rounds, in the same way as long multiplication on paper. Each 16-bit partial product goes into a result accumulator at the matching byte offset in the cycle it is produced. The accumulator is cleared when an operation starts.

A one-cycle start pulse captures both operands and two mode bits. The first mode bit picks a full 64-bit product or a truncated low 32-bit product. In truncated mode the block skips every digit pair that cannot affect the low word, which cuts the operation from 16 cycles to 10. The second mode bit picks signed or unsigned operands. In signed mode the operands are turned into magnitudes before the multiply, and the product is negated at the end when the operand signs differ. When the operation finishes, done pulses and the result is held on the output until the next operation completes.

Top module: `wmul_top`

## Requirements
- R1: After reset, busy_o and done_o are low and result_o is zero.
- R2: With full_i=1 and signed_i=0, result_o equals the unsigned 64-bit product a_i*b_i.
- R3: With full_i=0, result_o[31:0] holds the low 32 bits of the product for the selected signedness, and result_o[63:32] is zero.
- R4: With signed_i=1, the operands are read as two's complement values. result_o equals their two's complement product, and this includes operands of 0x80000000.
- R5: A full operation keeps busy_o high for 16 cycles after the start edge and a truncated one for 10. done_o rises on the edge that ends the last busy cycle and is never high together with busy_o.
- R6: done_o is high for exactly one cycle. result_o changes only on that cycle and then holds its value.
- R7: A start_i pulse that arrives while busy_o is high is ignored. The operation in flight keeps its latched operands, its mode and its length.
- R8: The carry out of every partial-product add ripples through all higher result bytes. A case is all-ones operands, whose full product is 0xFFFFFFFE00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only while idle |
| a_i | input | 32 | Multiplicand |
| b_i | input | 32 | Multiplier |
| full_i | input | 1 | 1: 64-bit product, 0: truncated 32-bit product |
| signed_i | input | 1 | 1: operands are two's complement |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Product, held until the next completion |

## Verification
A table of operand pairs is tried in each mode. Zero and small operands catch a wrong byte offset. All-ones operands produce a carry out of every byte, which shows whether carries ripple upward. Patterns with alternating bytes set separate the digit pairs that truncated mode skips from those it keeps. In signed mode, mixed-sign pairs and 0x80000000 operands test the magnitude and negation steps. Directed tests then count busy cycles in each mode, fire a second start in mid-operation, and check that the result holds after done.

// File: rtl/wmul_pkg.sv
package wmul_pkg;
  localparam int unsigned DIG_W_DEF = 8;
  localparam int unsigned N_DIG_DEF = 4;

  typedef struct packed {
    logic full;
    logic neg;
  } op_mode_t;
endpackage

// File: rtl/wmul_sign.sv
module wmul_sign #(
  parameter int unsigned OPW = 32
) (
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic           signed_i,
  output logic [OPW-1:0] mag_a_o,
  output logic [OPW-1:0] mag_b_o,
  output logic           neg_o
);
  logic sa, sb;
  assign sa = signed_i & a_i[OPW-1];
  assign sb = signed_i & b_i[OPW-1];
  // most negative value maps onto itself, read as unsigned
  assign mag_a_o = sa ? (OPW'(0) - a_i) : a_i;
  assign mag_b_o = sb ? (OPW'(0) - b_i) : b_i;
  assign neg_o   = sa ^ sb;
endmodule

// File: rtl/wmul_mul8.sv
module wmul_mul8 #(
  parameter int unsigned DIG_W = 8
) (
  input  logic [DIG_W-1:0]   x_i,
  input  logic [DIG_W-1:0]   y_i,
  output logic [2*DIG_W-1:0] p_o
);
  assign p_o = (2*DIG_W)'(x_i) * (2*DIG_W)'(y_i);
endmodule

// File: rtl/wmul_seq.sv
module wmul_seq #(
  parameter int unsigned N_DIG = 4,
  localparam int unsigned IW   = (N_DIG > 1) ? $clog2(N_DIG) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          full_i,
  output logic          load_o,
  output logic          busy_o,
  output logic          last_o,
  output logic          full_o,
  output logic [IW-1:0] i_o,
  output logic [IW-1:0] j_o
);
  logic          busy_q, full_q;
  logic [IW-1:0] i_q, j_q, j_end;

  assign load_o = start_i & ~busy_q;
  // truncated rounds stop at column N_DIG-1
  assign j_end  = full_q ? IW'(N_DIG-1) : (IW'(N_DIG-1) - i_q);
  assign last_o = busy_q && (i_q == IW'(N_DIG-1)) && (j_q == j_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      full_q <= 1'b0;
      i_q    <= '0;
      j_q    <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      full_q <= full_i;
      i_q    <= '0;
      j_q    <= '0;
    end else if (busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
      end else if (j_q == j_end) begin
        i_q <= i_q + 1'b1;
        j_q <= '0;
      end else begin
        j_q <= j_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign full_o = full_q;
  assign i_o    = i_q;
  assign j_o    = j_q;
endmodule

// File: rtl/wmul_acc.sv
module wmul_acc #(
  parameter int unsigned DIG_W = 8,
  parameter int unsigned N_DIG = 4,
  localparam int unsigned OPW  = DIG_W*N_DIG,
  localparam int unsigned RW   = 2*OPW,
  localparam int unsigned OW   = $clog2(2*N_DIG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               add_i,
  input  logic               full_i,
  input  logic [OW-1:0]      off_i,
  input  logic [2*DIG_W-1:0] pp_i,
  output logic [RW-1:0]      mask_o,
  output logic [RW-1:0]      nxt_o
);
  logic [RW-1:0] acc_q, shifted, sum;

  assign mask_o  = full_i ? {RW{1'b1}} : {{OPW{1'b0}}, {OPW{1'b1}}};
  assign shifted = RW'(pp_i) << (off_i * DIG_W);
  assign sum     = acc_q + shifted;
  // carries past the kept width are dropped
  assign nxt_o   = sum & mask_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (add_i)   acc_q <= nxt_o;
  end
endmodule

// File: rtl/wmul_top.sv
module wmul_top
  import wmul_pkg::*;
#(
  parameter int unsigned DIG_W = DIG_W_DEF,
  parameter int unsigned N_DIG = N_DIG_DEF,
  localparam int unsigned OPW  = DIG_W*N_DIG,
  localparam int unsigned RW   = 2*OPW,
  localparam int unsigned IW   = (N_DIG > 1) ? $clog2(N_DIG) : 1,
  localparam int unsigned OW   = $clog2(2*N_DIG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [OPW-1:0] a_i,
  input  logic [OPW-1:0] b_i,
  input  logic           full_i,
  input  logic           signed_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [RW-1:0]  result_o
);
  logic [OPW-1:0]     mag_a, mag_b, a_q, b_q;
  logic               neg;
  op_mode_t           mode_q;
  logic               load, busy, last, full_q;
  logic [IW-1:0]      i_idx, j_idx;
  logic [DIG_W-1:0]   a_dig, b_dig;
  logic [2*DIG_W-1:0] pp;
  logic [RW-1:0]      mask, acc_nxt, res_q, fixed;
  logic               done_q;

  wmul_sign #(.OPW(OPW)) u_sign (
    .a_i(a_i), .b_i(b_i), .signed_i(signed_i),
    .mag_a_o(mag_a), .mag_b_o(mag_b), .neg_o(neg)
  );

  wmul_seq #(.N_DIG(N_DIG)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .full_i(full_i),
    .load_o(load), .busy_o(busy), .last_o(last), .full_o(full_q),
    .i_o(i_idx), .j_o(j_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= '0;
    end else if (load) begin
      a_q    <= mag_a;
      b_q    <= mag_b;
      mode_q <= '{full: full_i, neg: neg};
    end
  end

  assign a_dig = a_q[j_idx*DIG_W +: DIG_W];
  assign b_dig = b_q[i_idx*DIG_W +: DIG_W];

  wmul_mul8 #(.DIG_W(DIG_W)) u_mul (.x_i(b_dig), .y_i(a_dig), .p_o(pp));

  wmul_acc #(.DIG_W(DIG_W), .N_DIG(N_DIG)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(load), .add_i(busy),
    .full_i(full_q), .off_i(OW'(i_idx) + OW'(j_idx)), .pp_i(pp),
    .mask_o(mask), .nxt_o(acc_nxt)
  );

  assign fixed = mode_q.neg ? ((RW'(0) - acc_nxt) & mask) : acc_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last;
      if (last) res_q <= fixed;
    end
  end

  assign busy_o   = busy;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/wmul_chk.sv
module wmul_chk #(
  parameter int unsigned OPW   = 32,
  parameter int unsigned N_DIG = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           start_i,
  input logic           full_i,
  input logic           busy_o,
  input logic           done_o,
  input logic [2*OPW-1:0] result_o,
  input logic [OPW-1:0] a_q,
  input logic [OPW-1:0] b_q
);
  localparam int unsigned N_FULL  = N_DIG*N_DIG;
  localparam int unsigned N_TRUNC = N_DIG*(N_DIG+1)/2;

  logic        full_seen;
  int unsigned cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_seen <= 1'b0;
      cnt       <= 0;
    end else if (start_i && !busy_o) begin
      full_seen <= full_i;
      cnt       <= 0;
    end else if (busy_o) begin
      cnt <= cnt + 1;
    end
  end

  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cnt == (full_seen ? N_FULL : N_TRUNC)));
  a_r5_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  a_r6_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
  a_r3_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !full_seen) |-> (result_o[2*OPW-1:OPW] == '0));
  a_r7_ops_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(a_q) && $stable(b_q)));
endmodule

bind wmul_top wmul_chk #(.OPW(OPW), .N_DIG(N_DIG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .full_i(full_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
  .a_q(a_q), .b_q(b_q)
);

// File: tb/tb_wmul_top.sv
`timescale 1ns/1ps
module tb_wmul_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        full_i = 1'b0, signed_i = 1'b0;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int tests = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  wmul_top dut (.*);

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        full;
    logic        sgn;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b1, 1'b0},
    '{32'h1234_5678, 32'h9ABC_DEF0, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0},
    '{32'h0000_0001, 32'hFFFF_FFFF, 1'b1, 1'b0},
    '{32'h00FF_00FF, 32'hFF00_FF00, 1'b0, 1'b0},
    '{32'h0000_FFFF, 32'h0000_FFFF, 1'b1, 1'b0},
    '{32'hFFFF_FFFF, 32'h0000_0002, 1'b1, 1'b1},
    '{32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1},
    '{32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1},
    '{32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1},
    '{32'h7FFF_FFFF, 32'h8000_0001, 1'b1, 1'b1},
    '{32'hDEAD_BEEF, 32'h0123_4567, 1'b0, 1'b1},
    '{32'hFEDC_BA98, 32'h8765_4321, 1'b0, 1'b0}
  };

  function automatic logic [63:0] model(logic [31:0] a, logic [31:0] b, logic full, logic sgn);
    logic [63:0] p;
    if (sgn) p = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
    else     p = {32'b0, a} * {32'b0, b};
    if (!full) p = {32'b0, p[31:0]};
    return p;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drives one start, returns busy-cycle count and result
  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic full,
                     input logic sgn, output logic [63:0] res, output int n);
    @(negedge clk_i);
    a_i = a; b_i = b; full_i = full; signed_i = sgn; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    n = 0;
    while (!done_o) begin
      @(negedge clk_i);
      n++;
    end
    res = result_o;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] r, r2;
    int n;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 busy", 64'(busy_o), 64'd0);
    check("R1 done", 64'(done_o), 64'd0);
    check("R1 result", result_o, 64'd0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      run(VECS[k].a, VECS[k].b, VECS[k].full, VECS[k].sgn, r, n);
      check(VECS[k].sgn ? "R4 signed product" : (VECS[k].full ? "R2 full product" : "R3 truncated product"),
            r, model(VECS[k].a, VECS[k].b, VECS[k].full, VECS[k].sgn));
      check("R5 latency", 64'(n), VECS[k].full ? 64'd16 : 64'd10);
      @(negedge clk_i);
      check("R6 done one cycle", 64'(done_o), 64'd0);
    end

    // R8 carry ripple through every byte
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, r, n);
    check("R8 all-ones carry", r, 64'hFFFF_FFFE_0000_0001);
    // R4 most negative squared
    run(32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, r, n);
    check("R4 min squared", r, 64'h4000_0000_0000_0000);
    // R3 truncated, upper half zero
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b0, r, n);
    check("R3 low word only", r, 64'h0000_0000_0000_0001);

    // R7 start while busy is ignored
    @(negedge clk_i);
    a_i = 32'h0001_0203; b_i = 32'h0405_0607; full_i = 1'b1; signed_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R5 busy after start", 64'(busy_o), 64'd1);
    n = 0;
    repeat (3) begin @(negedge clk_i); n++; end
    a_i = 32'hFFFF_FFFF; b_i = 32'h1357_9BDF; full_i = 1'b0; signed_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i); n++;
    start_i = 1'b0;
    while (!done_o) begin @(negedge clk_i); n++; end
    check("R7 ignored start result", result_o, model(32'h0001_0203, 32'h0405_0607, 1'b1, 1'b0));
    check("R7 ignored start length", 64'(n), 64'd16);
    r = result_o;
    repeat (5) @(negedge clk_i);
    check("R7 no second run", 64'(busy_o), 64'd0);
    check("R6 result held", result_o, r);

    // follow-up operation still works after the ignored start
    run(32'hFFFF_FFFE, 32'h0000_0003, 1'b0, 1'b1, r2, n);
    check("R4 truncated signed", r2, model(32'hFFFF_FFFE, 32'h0000_0003, 1'b0, 1'b1));
    check("R5 truncated latency", 64'(n), 64'd10);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule